// File: doc/BRIEF.md
# Floating-Point-Disabled Trap Entry Unit

This unit watches the instruction that the decode stage of a small 32-bit processor presents each cycle. When the status register says floating-point work is switched off and the instruction belongs to the floating-point class, it raises a trap. In the same step it computes every register update that exception entry needs: the saved program counter, the saved status word, a shadow copy of the stack register R15, the event code, the new status word and the vector address to fetch from next.

An instruction is floating-point class when its top four opcode bits are all ones, except for one reserved undefined opcode. A configurable table of masked encodings adds the moves of the FPU communication register and the FPU control register to and from general registers and memory. A floating-point instruction that sits in a branch delay slot does not take this trap. Instead it raises a separate one-cycle flag, and another unit handles that case. All results are registered by default, so they appear one clock after the instruction is presented. An update output carries data only while its qualifying strobe is high.

Top module: `fpdis_trap_entry`

## Requirements
- R1: With `dec_valid_i`=1, `in_slot_i`=0 and status bit 15 (the FPU-disable bit) set, any opcode whose bits [15:12] are 4'hF, other than 16'hFFFD, gives `trap_valid_o`=1 on the cycle after it is presented.
- R2: Opcode 16'hFFFD never raises `trap_valid_o` or `slot_trap_o`.
- R3: With the default table, an opcode matches the transfer class when (opcode & 16'hF0FF) is one of 16'h405A, 16'h4056, 16'h406A, 16'h4066, 16'h005A, 16'h006A, 16'h4052 or 16'h4062. Such an opcode traps under the conditions of R1. No other opcode whose top nibble is not 4'hF traps.
- R4: When status bit 15 is 0, no instruction raises `trap_valid_o` or `slot_trap_o`.
- R5: A floating-point-class instruction with `in_slot_i`=1 and status bit 15 set gives `slot_trap_o`=1 for one cycle with `trap_valid_o`=0. `trap_valid_o` and `slot_trap_o` are never high together.
- R6: On a trap, `spc_o`, `ssr_o` and `sgr_o` equal the `pc_i`, `sr_i` and `r15_i` of the faulting instruction.
- R7: On a trap, `expevt_o` is 32'h0000_0800.
- R8: On a trap, `sr_o` equals the incoming status word with bits 30, 29 and 28 forced to 1 and every other bit unchanged.
- R9: On a trap, `pc_o` equals `vbr_i` + 32'h100, wrapping modulo 2^32.
- R10: Outputs are registered with one cycle of latency. Each trapping instruction gives exactly one cycle of `trap_valid_o`. While `trap_valid_o` is 0, all six update outputs are 0.
- R11: With `dec_valid_i`=0, no trap and no slot flag are raised, whatever the other inputs are.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | A real instruction is presented this cycle |
| insn_i | input | 16 | Opcode being decoded |
| in_slot_i | input | 1 | Instruction sits in a branch delay slot |
| sr_i | input | 32 | Current status register |
| pc_i | input | 32 | Address of the instruction |
| r15_i | input | 32 | Current R15 value |
| vbr_i | input | 32 | Vector base register |
| trap_valid_o | output | 1 | One-cycle trap strobe; qualifies the update outputs |
| slot_trap_o | output | 1 | One-cycle flag for the delay-slot case |
| spc_o | output | 32 | Value for the saved-PC register |
| ssr_o | output | 32 | Value for the saved-status register |
| sgr_o | output | 32 | Value for the R15 shadow register |
| expevt_o | output | 32 | Value for the event code register |
| sr_o | output | 32 | New status register value |
| pc_o | output | 32 | Redirected fetch address |

## Verification
The bench sweeps all 65536 opcodes with floating point disabled, so a decoder that mis-sizes the nibble test, forgets the 16'hFFFD exclusion or masks the register field wrongly in a transfer entry shows up as a wrong strobe on a specific opcode. Further sweeps repeat the floating-point opcodes with the disable bit clear, inside a delay slot and with `dec_valid_i` low. A unit that ignored any of these gates would fire where it must stay silent, or would raise the main trap instead of the slot flag. Directed cases place a vector base just below the 32-bit limit, to catch a saturating or truncated adder. They also use status words that have the entry bits already set or cleared, to catch a design that overwrites bits it should keep. Back-to-back traps check that the strobe neither stretches nor drops a cycle.

// File: rtl/fpdis_pkg.sv
package fpdis_pkg;

   // Decode verdict for one opcode.
   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_NIBBLE = 2'd1,
      CLS_XFER   = 2'd2
   } fpu_cls_e;

   // Default transfer table: communication / control register moves.
   localparam int unsigned XFER_DEF_N = 8;

   localparam logic [XFER_DEF_N*16-1:0] XFER_DEF_PAT = {
      16'h4062, 16'h4052, 16'h006A, 16'h005A,
      16'h4066, 16'h406A, 16'h4056, 16'h405A
   };

   // Register field (bits 11:8) is a don't-care for every entry.
   localparam logic [XFER_DEF_N*16-1:0] XFER_DEF_MASK = {XFER_DEF_N{16'hF0FF}};

   function automatic logic fpu_class(input fpu_cls_e c);
      return c != CLS_NONE;
   endfunction

endpackage

// File: rtl/fpdis_class_decode.sv
module fpdis_class_decode
   import fpdis_pkg::*;
#(
   parameter int unsigned INSN_W        = 16,
   parameter logic [3:0]  CLASS_NIBBLE  = 4'hF,
   parameter bit          EXCLUDE_EN    = 1'b1,
   parameter logic [INSN_W-1:0] EXCLUDED_OP = 16'hFFFD,
   parameter int unsigned XFER_N        = XFER_DEF_N,
   parameter logic [XFER_N*INSN_W-1:0] XFER_PAT  = XFER_DEF_PAT,
   parameter logic [XFER_N*INSN_W-1:0] XFER_MASK = XFER_DEF_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_i,
   output fpu_cls_e          cls_o
);

   localparam int unsigned NIB_LSB = INSN_W - 4;

   logic [XFER_N-1:0] hit;
   logic              nib_hit;
   logic              excl_hit;

   generate
      for (genvar i = 0; i < XFER_N; i++) begin : g_xfer
         localparam logic [INSN_W-1:0] PAT_I  = XFER_PAT[i*INSN_W +: INSN_W];
         localparam logic [INSN_W-1:0] MASK_I = XFER_MASK[i*INSN_W +: INSN_W];
         assign hit[i] = (insn_i & MASK_I) == (PAT_I & MASK_I);
      end

      if (EXCLUDE_EN) begin : g_excl
         assign excl_hit = (insn_i == EXCLUDED_OP);
      end else begin : g_no_excl
         assign excl_hit = 1'b0;
      end
   endgenerate

   assign nib_hit = (insn_i[INSN_W-1:NIB_LSB] == CLASS_NIBBLE);

   always_comb begin
      cls_o = CLS_NONE;
      if (nib_hit && !excl_hit) begin
         cls_o = CLS_NIBBLE;
      end else if (|hit && !excl_hit) begin
         cls_o = CLS_XFER;
      end
   end

   // Transfer entries must not overlap one another.
   AST_XFER_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R3

   // The reserved opcode never decodes as floating point.
   AST_EXCL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (EXCLUDE_EN && insn_i == EXCLUDED_OP) |-> cls_o == CLS_NONE); // R2

endmodule

// File: rtl/fpdis_trap_cond.sv
module fpdis_trap_cond
   import fpdis_pkg::*;
(
   input  logic     dec_valid_i,
   input  fpu_cls_e cls_i,
   input  logic     in_slot_i,
   input  logic     fd_i,
   output logic     take_o,
   output logic     slot_o
);

   logic armed;

   assign armed  = dec_valid_i && fd_i && fpu_class(cls_i);
   assign take_o = armed && !in_slot_i;
   assign slot_o = armed &&  in_slot_i;

endmodule

// File: rtl/fpdis_entry_calc.sv
module fpdis_entry_calc #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SET_N      = 3,
   parameter logic [SET_N*8-1:0] SET_BITS = {8'd28, 8'd29, 8'd30},
   parameter logic [DATA_W-1:0] VEC_OFFSET = 32'h0000_0100,
   parameter logic [DATA_W-1:0] EVT_CODE   = 32'h0000_0800
) (
   input  logic [DATA_W-1:0] sr_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] r15_i,
   input  logic [DATA_W-1:0] vbr_i,
   output logic [DATA_W-1:0] spc_o,
   output logic [DATA_W-1:0] ssr_o,
   output logic [DATA_W-1:0] sgr_o,
   output logic [DATA_W-1:0] expevt_o,
   output logic [DATA_W-1:0] sr_o,
   output logic [DATA_W-1:0] pc_o
);

   logic [SET_N:0][DATA_W-1:0] set_mask;

   assign set_mask[0] = '0;

   generate
      for (genvar i = 0; i < SET_N; i++) begin : g_setbit
         localparam int unsigned POS = int'(SET_BITS[i*8 +: 8]);
         assign set_mask[i+1] = set_mask[i] | (DATA_W'(1) << POS);
      end
   endgenerate

   assign spc_o    = pc_i;
   assign ssr_o    = sr_i;
   assign sgr_o    = r15_i;
   assign expevt_o = EVT_CODE;
   assign sr_o     = sr_i | set_mask[SET_N];
   assign pc_o     = vbr_i + VEC_OFFSET;

endmodule

// File: rtl/fpdis_trap_entry.sv
module fpdis_trap_entry
   import fpdis_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned INSN_W      = 16,
   parameter int unsigned FD_BIT      = 15,
   parameter int unsigned MD_BIT      = 30,
   parameter int unsigned RB_BIT      = 29,
   parameter int unsigned BL_BIT      = 28,
   parameter bit          REGISTER_OUT = 1'b1,
   parameter logic [3:0]  CLASS_NIBBLE = 4'hF,
   parameter bit          EXCLUDE_EN   = 1'b1,
   parameter logic [INSN_W-1:0] EXCLUDED_OP = 16'hFFFD,
   parameter logic [DATA_W-1:0] VEC_OFFSET  = 32'h0000_0100,
   parameter logic [DATA_W-1:0] EVT_CODE    = 32'h0000_0800,
   parameter int unsigned XFER_N      = XFER_DEF_N,
   parameter logic [XFER_N*INSN_W-1:0] XFER_PAT  = XFER_DEF_PAT,
   parameter logic [XFER_N*INSN_W-1:0] XFER_MASK = XFER_DEF_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_valid_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic              in_slot_i,
   input  logic [DATA_W-1:0] sr_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] r15_i,
   input  logic [DATA_W-1:0] vbr_i,
   output logic              trap_valid_o,
   output logic              slot_trap_o,
   output logic [DATA_W-1:0] spc_o,
   output logic [DATA_W-1:0] ssr_o,
   output logic [DATA_W-1:0] sgr_o,
   output logic [DATA_W-1:0] expevt_o,
   output logic [DATA_W-1:0] sr_o,
   output logic [DATA_W-1:0] pc_o
);

   localparam int unsigned SET_N = 3;
   localparam logic [SET_N*8-1:0] SET_BITS = {8'(BL_BIT), 8'(RB_BIT), 8'(MD_BIT)};
   localparam logic [DATA_W-1:0] ENTRY_MASK =
      (DATA_W'(1) << MD_BIT) | (DATA_W'(1) << RB_BIT) | (DATA_W'(1) << BL_BIT);

   // Elaboration-time parameter checks.
   generate
      if (INSN_W < 8)                      begin : g_chk_insn  $error("INSN_W too small");           end
      if (DATA_W < 8 || DATA_W > 255)      begin : g_chk_data  $error("DATA_W out of range");        end
      if (FD_BIT >= DATA_W)                begin : g_chk_fd    $error("FD_BIT outside status word"); end
      if (MD_BIT >= DATA_W || RB_BIT >= DATA_W || BL_BIT >= DATA_W)
                                           begin : g_chk_ent   $error("entry bit outside word");     end
      if (MD_BIT == RB_BIT || MD_BIT == BL_BIT || RB_BIT == BL_BIT)
                                           begin : g_chk_dist  $error("entry bits must differ");     end
      if (FD_BIT == MD_BIT || FD_BIT == RB_BIT || FD_BIT == BL_BIT)
                                           begin : g_chk_fdov  $error("FD_BIT overlaps entry bits"); end
      if (XFER_N < 1)                      begin : g_chk_xfer  $error("XFER_N must be positive");    end
   endgenerate

   fpu_cls_e cls;
   logic     take_c;
   logic     slot_c;
   logic [DATA_W-1:0] spc_c, ssr_c, sgr_c, evt_c, sr_c, pc_c;

   fpdis_class_decode #(
      .INSN_W       (INSN_W),
      .CLASS_NIBBLE (CLASS_NIBBLE),
      .EXCLUDE_EN   (EXCLUDE_EN),
      .EXCLUDED_OP  (EXCLUDED_OP),
      .XFER_N       (XFER_N),
      .XFER_PAT     (XFER_PAT),
      .XFER_MASK    (XFER_MASK)
   ) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .insn_i (insn_i),
      .cls_o  (cls)
   );

   fpdis_trap_cond u_cond (
      .dec_valid_i (dec_valid_i),
      .cls_i       (cls),
      .in_slot_i   (in_slot_i),
      .fd_i        (sr_i[FD_BIT]),
      .take_o      (take_c),
      .slot_o      (slot_c)
   );

   fpdis_entry_calc #(
      .DATA_W     (DATA_W),
      .SET_N      (SET_N),
      .SET_BITS   (SET_BITS),
      .VEC_OFFSET (VEC_OFFSET),
      .EVT_CODE   (EVT_CODE)
   ) u_calc (
      .sr_i     (sr_i),
      .pc_i     (pc_i),
      .r15_i    (r15_i),
      .vbr_i    (vbr_i),
      .spc_o    (spc_c),
      .ssr_o    (ssr_c),
      .sgr_o    (sgr_c),
      .expevt_o (evt_c),
      .sr_o     (sr_c),
      .pc_o     (pc_c)
   );

   generate
      if (REGISTER_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               trap_valid_o <= 1'b0;
               slot_trap_o  <= 1'b0;
               spc_o        <= '0;
               ssr_o        <= '0;
               sgr_o        <= '0;
               expevt_o     <= '0;
               sr_o         <= '0;
               pc_o         <= '0;
            end else begin
               trap_valid_o <= take_c;
               slot_trap_o  <= slot_c;
               spc_o        <= take_c ? spc_c : '0;
               ssr_o        <= take_c ? ssr_c : '0;
               sgr_o        <= take_c ? sgr_c : '0;
               expevt_o     <= take_c ? evt_c : '0;
               sr_o         <= take_c ? sr_c  : '0;
               pc_o         <= take_c ? pc_c  : '0;
            end
         end

         AST_GATE_FD: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid_o |-> ($past(sr_i[FD_BIT]) && !$past(in_slot_i))); // R4

         AST_NOT_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
            (trap_valid_o || slot_trap_o) |-> !(EXCLUDE_EN && $past(insn_i) == EXCLUDED_OP)); // R2

         AST_SLOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            slot_trap_o |-> ($past(in_slot_i) && $past(sr_i[FD_BIT]))); // R5

         AST_SAVED_STATE: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid_o |-> (spc_o == $past(pc_i) && ssr_o == $past(sr_i)
                              && sgr_o == $past(r15_i))); // R6

         AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid_o |-> sr_o == ($past(sr_i) | ENTRY_MASK)); // R8

         AST_VECTOR_PC: assert property (@(posedge clk) disable iff (!rst_n)
            trap_valid_o |-> pc_o == ($past(vbr_i) + VEC_OFFSET)); // R9

         AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(dec_valid_i) |-> (!trap_valid_o && !slot_trap_o)); // R11
      end else begin : g_comb_out
         assign trap_valid_o = take_c;
         assign slot_trap_o  = slot_c;
         assign spc_o        = take_c ? spc_c : '0;
         assign ssr_o        = take_c ? ssr_c : '0;
         assign sgr_o        = take_c ? sgr_c : '0;
         assign expevt_o     = take_c ? evt_c : '0;
         assign sr_o         = take_c ? sr_c  : '0;
         assign pc_o         = take_c ? pc_c  : '0;
      end
   endgenerate

   AST_TRAP_SLOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_valid_o && slot_trap_o)); // R5

   AST_EVT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_o |-> expevt_o == EVT_CODE); // R7

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid_o |-> (spc_o == '0 && ssr_o == '0 && sgr_o == '0
                         && expevt_o == '0 && sr_o == '0 && pc_o == '0)); // R10

endmodule

// File: tb/fpdis_trap_entry_bench.sv
module fpdis_trap_entry_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dec_valid_i;
   logic [15:0] insn_i;
   logic        in_slot_i;
   logic [31:0] sr_i, pc_i, r15_i, vbr_i;
   logic        trap_valid_o, slot_trap_o;
   logic [31:0] spc_o, ssr_o, sgr_o, expevt_o, sr_o, pc_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpdis_trap_entry u_fpdis_trap_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec_valid_i  (dec_valid_i),
      .insn_i       (insn_i),
      .in_slot_i    (in_slot_i),
      .sr_i         (sr_i),
      .pc_i         (pc_i),
      .r15_i        (r15_i),
      .vbr_i        (vbr_i),
      .trap_valid_o (trap_valid_o),
      .slot_trap_o  (slot_trap_o),
      .spc_o        (spc_o),
      .ssr_o        (ssr_o),
      .sgr_o        (sgr_o),
      .expevt_o     (expevt_o),
      .sr_o         (sr_o),
      .pc_o         (pc_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Floating-point class computed from the requirement text (R1, R2, R3).
   function automatic bit exp_fpu(input logic [15:0] op);
      logic [15:0] k;
      k = op & 16'hF0FF;
      if (op[15:12] == 4'hF) return op != 16'hFFFD;
      return (k == 16'h405A) || (k == 16'h4056) || (k == 16'h406A) || (k == 16'h4066)
          || (k == 16'h005A) || (k == 16'h006A) || (k == 16'h4052) || (k == 16'h4062);
   endfunction

   // Present one instruction, wait for the registered result, check it.
   task automatic apply(input string req, input logic v, input logic [15:0] op,
                        input logic slot, input logic [31:0] sr, input logic [31:0] pc,
                        input logic [31:0] r15, input logic [31:0] vbr);
      bit fpu, e_trap, e_slot;
      fpu    = exp_fpu(op);
      e_trap = v && sr[15] && fpu && !slot;
      e_slot = v && sr[15] && fpu &&  slot;
      @(negedge clk);
      dec_valid_i = v; insn_i = op; in_slot_i = slot;
      sr_i = sr; pc_i = pc; r15_i = r15; vbr_i = vbr;
      @(posedge clk);
      #1;
      chk(req, "trap_valid", {31'd0, trap_valid_o}, {31'd0, e_trap});
      chk(e_slot ? "R5" : req, "slot_trap", {31'd0, slot_trap_o}, {31'd0, e_slot});
      if (e_trap) begin
         chk("R6", "spc", spc_o, pc);
         chk("R6", "ssr", ssr_o, sr);
         chk("R6", "sgr", sgr_o, r15);
         chk("R7", "expevt", expevt_o, 32'h0000_0800);
         chk("R8", "sr", sr_o, sr | 32'h7000_0000);
         chk("R9", "pc", pc_o, vbr + 32'h0000_0100);
      end else begin
         chk("R10", "quiet", spc_o | ssr_o | sgr_o | expevt_o | sr_o | pc_o, 32'd0);
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      dec_valid_i = 1'b1; insn_i = 16'hF000; in_slot_i = 1'b0;
      sr_i = 32'h0000_8000; pc_i = 32'h1; r15_i = 32'h2; vbr_i = 32'h3;
      repeat (3) @(posedge clk);
      #1;
      // R12: reset holds all outputs at zero even with a trapping input.
      chk("R12", "reset strobes", {30'd0, trap_valid_o, slot_trap_o}, 32'd0);
      chk("R12", "reset data", spc_o | ssr_o | sgr_o | expevt_o | sr_o | pc_o, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R3: full opcode sweep with FD set, outside a delay slot.
      for (int i = 0; i < 65536; i++) begin
         logic [15:0] op;
         string req;
         op = 16'(i);
         if (op == 16'hFFFD)          req = "R2";
         else if (op[15:12] == 4'hF)  req = "R1";
         else                         req = "R3";
         apply(req, 1'b1, op, 1'b0, {op, 16'h80F3}, {16'hA000, op},
               {op, ~op}, {~op, 16'h0F00});
      end

      // R4: FD clear, every top-nibble-F opcode and every transfer form.
      for (int i = 0; i < 4096; i++) begin
         apply("R4", 1'b1, 16'hF000 | 16'(i), 1'b0, 32'hFFFF_7FFF, 32'h10, 32'h20, 32'h30);
      end
      for (int r = 0; r < 16; r++) begin
         apply("R4", 1'b1, 16'h405A | 16'(r << 8), 1'b0, 32'h7000_0000, 32'h0, 32'h0, 32'h0);
      end

      // R5: inside a delay slot, slot flag only.
      for (int i = 0; i < 4096; i++) begin
         apply("R5", 1'b1, 16'hF000 | 16'(i), 1'b1, 32'h0000_8000, 32'h44, 32'h55, 32'h66);
      end
      apply("R5", 1'b1, 16'h4362, 1'b1, 32'h0000_8000, 32'h44, 32'h55, 32'h66);
      apply("R2", 1'b1, 16'hFFFD, 1'b1, 32'h0000_8000, 32'h44, 32'h55, 32'h66);

      // R11: no valid instruction means nothing happens.
      for (int i = 0; i < 4096; i++) begin
         apply("R11", 1'b0, 16'hF000 | 16'(i), i[0], 32'hFFFF_FFFF, 32'h1, 32'h2, 32'h3);
      end

      // R8 R9: status word corner values, vector wrap.
      apply("R8", 1'b1, 16'hF00C, 1'b0, 32'h0000_8000, 32'h0C00_0000, 32'h8C00_0000, 32'hFFFF_FF80);
      apply("R8", 1'b1, 16'hF1AD, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0, 32'hFFFF_FF00);
      apply("R9", 1'b1, 16'h0A5A, 1'b0, 32'h8FFF_8FFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      // R10: back-to-back traps keep the strobe high once per instruction,
      // then a bubble drops it.
      apply("R10", 1'b1, 16'hF123, 1'b0, 32'h0000_8000, 32'h100, 32'h200, 32'h300);
      apply("R10", 1'b1, 16'hF456, 1'b0, 32'h0000_8001, 32'h104, 32'h204, 32'h304);
      apply("R10", 1'b1, 16'h0009, 1'b0, 32'h0000_8000, 32'h108, 32'h208, 32'h308);
      apply("R10", 1'b1, 16'h4F66, 1'b0, 32'h0000_8000, 32'h10C, 32'h20C, 32'h30C);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule